// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block drives the opening of an I2C transfer on behalf of a requester. The requester presents a target address and a read/write flag through a valid/ready handshake. The sequencer looks at the address value to pick either the short (7-bit) or the long (10-bit) addressing form. It then commands a downstream byte engine, one command at a time, to place a start condition on the bus followed by one or two address bytes. When the address phase is over it reports a single status.

Each command waits for a response from the engine before the next one is issued. A negative acknowledge or a timeout from the engine ends the sequence at once, and that outcome is reported unchanged. Addresses in the reserved short range, and addresses beyond the long range, are refused before any command is issued. The block serves one request at a time. Data bytes, stop conditions and repeated starts are left to the logic that follows it.

Top module: `aps_seq`

## Requirements
- R1: An address below 0x80 whose bits 6:3 are not all ones produces exactly two commands: a start (cmd_op=0), then a write (cmd_op=1) of the byte {addr[6:0], rd}.
- R2: An address in 0x78..0x7F is refused. done rises in the cycle after acceptance with status 2 (invalid), and no command is issued.
- R3: An address in 0x80..0x3FF produces a start, then a write of bits 15:8 of the word 0xF000 | (addr<<1) | rd, then a write of bits 7:0 of that word.
- R4: An address of 0x400 or above is refused with status 2, and no command is issued.
- R5: A response code of 1 (not acknowledged) to any command ends the sequence with status 1, and no further command is issued. This includes the first byte of a 10-bit address.
- R6: A response code of 3 (engine timeout) ends the sequence with status 3, passed through unchanged, and the block returns to idle.
- R7: cmd_stop is 0 on every command the block issues.
- R8: After reset, req_ready=1, done=0 and cmd_valid=0. done is a one-cycle pulse. req_ready is 0 from acceptance until the cycle after done. Status 0 means success.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_op and cmd_byte hold their values. cmd_valid falls in the cycle after the command is accepted.
- R10: After the response to the last command with code 0, done rises in the next cycle with status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_addr | input | ADDR_W | Target address |
| req_rd | input | 1 | 1 = read transfer |
| cmd_valid | output | 1 | Command to engine is valid |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 1 | 0 = start, 1 = write byte |
| cmd_byte | output | 8 | Byte to write |
| cmd_stop | output | 1 | Stop-after request flag |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_code | input | 2 | 0 ok, 1 nack, 3 timeout |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 nack, 2 invalid, 3 timeout |

## Verification
Directed addresses sit on every range edge: 0x00, 0x77, 0x78, 0x7F, 0x80, 0x3FF, 0x400 and 0x7FF. These separate the short path, the reserved refusal, the long path and the out-of-range refusal. Failures are injected at the start, at the first address byte and at the second address byte, and each failure carries either a nack or a timeout code. This shows early termination at each position and that the code is passed through. Random addresses over the full 11-bit field, with random read flags, random engine stalls and random failure points, exercise the byte formation and the handshake timing against a model computed in the bench.

// File: rtl/aps_pkg.sv
package aps_pkg;

    localparam int SHORT_BITS = 7;
    localparam int LONG_BITS  = 10;
    localparam int RESV_W     = 4;
    localparam logic [4:0] LONG_MARK = 5'b11110;

    typedef enum logic {
        OP_START = 1'b0,
        OP_WRITE = 1'b1
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NACK    = 2'd1,
        ST_INVALID = 2'd2,
        ST_TIMEOUT = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        KIND_SHORT = 2'd0,
        KIND_LONG  = 2'd1,
        KIND_BAD   = 2'd2
    } addr_kind_e;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_ISSUE = 2'd1,
        C_WAIT  = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        addr_kind_e kind;
        logic [7:0] hi_byte;
        logic [7:0] lo_byte;
    } addr_plan_t;

    typedef struct packed {
        cmd_op_e    op;
        logic [7:0] data;
        logic       stop;
    } cmd_t;

    // Index of the final command for a given addressing kind.
    function automatic logic [1:0] last_step(addr_kind_e k);
        return (k == KIND_LONG) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/aps_decode.sv
module aps_decode
    import aps_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output addr_plan_t        plan
);
    logic fits_short;
    logic fits_long;
    logic reserved;

    always_comb begin
        fits_short = (addr >> SHORT_BITS) == '0;
        fits_long  = (addr >> LONG_BITS) == '0;
        reserved   = &addr[SHORT_BITS-1 -: RESV_W];

        plan.lo_byte = {addr[SHORT_BITS-1:0], rd};
        plan.hi_byte = {LONG_MARK, addr[LONG_BITS-1:SHORT_BITS]};

        if (!fits_long || (fits_short && reserved)) begin
            plan.kind = KIND_BAD;
        end else if (fits_short) begin
            plan.kind = KIND_SHORT;
        end else begin
            plan.kind = KIND_LONG;
        end
    end
endmodule

// File: rtl/aps_cmd_build.sv
module aps_cmd_build
    import aps_pkg::*;
(
    input  logic [1:0] step,
    input  addr_plan_t plan,
    output cmd_t       cmd
);
    always_comb begin
        cmd.stop = 1'b0;
        unique case (step)
            2'd0: begin
                cmd.op   = OP_START;
                cmd.data = 8'h00;
            end
            2'd1: begin
                cmd.op   = OP_WRITE;
                cmd.data = (plan.kind == KIND_LONG) ? plan.hi_byte : plan.lo_byte;
            end
            default: begin
                cmd.op   = OP_WRITE;
                cmd.data = plan.lo_byte;
            end
        endcase
    end
endmodule

// File: rtl/aps_ctrl.sv
module aps_ctrl
    import aps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  addr_plan_t plan_in,
    output logic       req_ready,
    output logic       cmd_valid,
    input  logic       cmd_ready,
    input  logic       rsp_valid,
    input  logic [1:0] rsp_code,
    output logic [1:0] step,
    output addr_plan_t plan_q,
    output logic       done,
    output status_e    status
);
    ctrl_state_e state;
    logic        done_q;
    status_e     stat_q;
    logic        finish;

    assign req_ready = (state == C_IDLE) && !done_q;
    assign cmd_valid = (state == C_ISSUE);
    assign done      = done_q;
    assign status    = stat_q;
    assign finish    = (rsp_code != ST_OK) || (step == last_step(plan_q.kind));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= C_IDLE;
            step   <= 2'd0;
            plan_q <= '0;
            done_q <= 1'b0;
            stat_q <= ST_OK;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                C_IDLE: begin
                    if (req_valid && req_ready) begin
                        plan_q <= plan_in;
                        step   <= 2'd0;
                        if (plan_in.kind == KIND_BAD) begin
                            done_q <= 1'b1;
                            stat_q <= ST_INVALID;
                        end else begin
                            state <= C_ISSUE;
                        end
                    end
                end
                C_ISSUE: begin
                    if (cmd_ready) begin
                        state <= C_WAIT;
                    end
                end
                C_WAIT: begin
                    if (rsp_valid) begin
                        if (finish) begin
                            done_q <= 1'b1;
                            stat_q <= status_e'(rsp_code);
                            state  <= C_IDLE;
                        end else begin
                            step  <= step + 2'd1;
                            state <= C_ISSUE;
                        end
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aps_seq.sv
module aps_seq
    import aps_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rd,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_op,
    output logic [7:0]        cmd_byte,
    output logic              cmd_stop,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_code,
    output logic              done,
    output logic [1:0]        status
);
    addr_plan_t plan_now;
    addr_plan_t plan_held;
    logic [1:0] step;
    cmd_t       cmd;
    status_e    stat_e;

    aps_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .rd   (req_rd),
        .plan (plan_now)
    );

    aps_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .plan_in   (plan_now),
        .req_ready (req_ready),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .step      (step),
        .plan_q    (plan_held),
        .done      (done),
        .status    (stat_e)
    );

    aps_cmd_build u_build (
        .step (step),
        .plan (plan_held),
        .cmd  (cmd)
    );

    assign cmd_op   = cmd.op;
    assign cmd_byte = cmd.data;
    assign cmd_stop = cmd.stop;
    assign status   = stat_e;
endmodule

// File: rtl/aps_seq_chk.sv
module aps_seq_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_op,
    input logic [7:0]        cmd_byte,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic              done,
    input logic [1:0]        status
);
    logic refused;
    assign refused = ((req_addr >> 10) != '0) ||
                     (((req_addr >> 7) == '0) && (req_addr[6:3] == 4'hF));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_op));

    // R2
    refuse_addr_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && refused |=> done && status == 2'd2 && !cmd_valid);

    // R1
    start_first_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !refused |=> cmd_valid && cmd_op == 1'b0);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R5
    nack_end_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == 2'd1 |=> done && status == 2'd1 && !cmd_valid);

    // R6
    timeout_pass_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_code == 2'd3 |=> done && status == 2'd3 && !cmd_valid);
endmodule

bind aps_seq aps_seq_chk #(.ADDR_W(ADDR_W)) u_aps_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .done      (done),
    .status    (status)
);

// File: tb/aps_seq_bench.sv
`timescale 1ns/1ps
module aps_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_rd;
    logic [10:0] req_addr;
    logic        cmd_valid, cmd_ready, cmd_op, cmd_stop;
    logic [7:0]  cmd_byte;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic        done;
    logic [1:0]  status;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    aps_seq #(.ADDR_W(11)) u_aps_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_rd(req_rd),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_stop(cmd_stop),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .done(done), .status(status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Expected commands and status derived from the requirements.
    task automatic expect_of(input logic [10:0] a, input logic rd, input int fail_at,
                             input logic [1:0] fcode, output int n, output logic [7:0] eb [0:2],
                             output logic [1:0] est, output string tag);
        logic [15:0] w;
        int full;
        eb[0] = 8'h00; eb[1] = 8'h00; eb[2] = 8'h00;
        w = 16'hF000 | ({5'b0, a} << 1) | {15'b0, rd};
        if (a >= 11'h400) begin
            n = 0; est = 2'd2; tag = "R4"; return;
        end
        if (a < 11'h80 && a[6:3] == 4'hF) begin
            n = 0; est = 2'd2; tag = "R2"; return;
        end
        if (a < 11'h80) begin
            full = 2; eb[1] = {a[6:0], rd}; tag = "R1";
        end else begin
            full = 3; eb[1] = w[15:8]; eb[2] = w[7:0]; tag = "R3";
        end
        if (fail_at < full) begin
            n = fail_at + 1; est = fcode;
            tag = (fcode == 2'd1) ? "R5" : "R6";
        end else begin
            n = full; est = 2'd0;
        end
    endtask

    task automatic run_txn(input logic [10:0] a, input logic rd, input int fail_at,
                           input logic [1:0] fcode);
        logic [7:0] eb [0:2];
        logic [1:0] est;
        logic [7:0] b0;
        string tag;
        int en;
        int seen = 0;
        int guard = 0;
        bit fin = 0;
        expect_of(a, rd, fail_at, fcode, en, eb, est, tag);
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
        req_addr = a; req_rd = rd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!fin && guard < 300) begin
            guard++;
            if (done) begin
                fin = 1;
                check(status == est, {tag, " status"}, int'(status), int'(est));
                check(seen == en, {tag, " command count"}, seen, en);
                check(cmd_valid == 1'b0, "R8 no command with done", int'(cmd_valid), 0);
                @(negedge clk);
                check(done == 1'b0, "R8 done one cycle", int'(done), 0);
                check(req_ready == 1'b1, "R8 ready after done", int'(req_ready), 1);
            end else if (cmd_valid) begin
                check(req_ready == 1'b0, "R8 busy", int'(req_ready), 0);
                b0 = cmd_byte;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                check(cmd_valid == 1'b1 && cmd_byte == b0, "R9 hold", int'(cmd_byte), int'(b0));
                check(cmd_stop == 1'b0, "R7 stop low", int'(cmd_stop), 0);
                if (seen < en) begin
                    check(cmd_op == (seen != 0), {tag, " op"}, int'(cmd_op), int'(seen != 0));
                    if (seen != 0)
                        check(cmd_byte == eb[seen], {tag, " byte"}, int'(cmd_byte), int'(eb[seen]));
                end else begin
                    check(1'b0, {tag, " extra command"}, seen, en);
                end
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                check(cmd_valid == 1'b0, "R9 drop after accept", int'(cmd_valid), 0);
                repeat ($urandom_range(0, 3)) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_code  = (seen == fail_at) ? fcode : 2'd0;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_code  = 2'd0;
                seen++;
            end else begin
                @(negedge clk);
            end
        end
        if (!fin) check(1'b0, {tag, " no done"}, 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_rd = 1'b0;
        cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_code = 2'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check(req_ready == 1'b1, "R8 reset ready", int'(req_ready), 1);
        check(done == 1'b0, "R8 reset done", int'(done), 0);
        check(cmd_valid == 1'b0, "R8 reset cmd_valid", int'(cmd_valid), 0);

        // R1 / R10 short addresses
        run_txn(11'h000, 1'b0, 9, 2'd0);
        run_txn(11'h077, 1'b1, 9, 2'd0);
        // R2 reserved pattern edges
        run_txn(11'h078, 1'b0, 9, 2'd0);
        run_txn(11'h07F, 1'b1, 9, 2'd0);
        // R3 long range edges
        run_txn(11'h080, 1'b0, 9, 2'd0);
        run_txn(11'h3FF, 1'b1, 9, 2'd0);
        // R4 out of range
        run_txn(11'h400, 1'b0, 9, 2'd0);
        run_txn(11'h7FF, 1'b1, 9, 2'd0);
        // R5 nack on first long byte, on short byte, on second long byte
        run_txn(11'h155, 1'b1, 1, 2'd1);
        run_txn(11'h02A, 1'b0, 1, 2'd1);
        run_txn(11'h2C3, 1'b0, 2, 2'd1);
        // R6 timeout at start and mid-sequence
        run_txn(11'h011, 1'b1, 0, 2'd3);
        run_txn(11'h1A0, 1'b1, 1, 2'd3);

        for (int i = 0; i < 80; i++) begin
            logic [10:0] a;
            logic r;
            int fa;
            logic [1:0] fc;
            a  = 11'($urandom_range(0, 11'h7FF));
            r  = 1'($urandom_range(0, 1));
            fa = $urandom_range(0, 5);
            fc = ($urandom_range(0, 1) == 0) ? 2'd1 : 2'd3;
            run_txn(a, r, fa, fc);
        end
        finish_run();
    end
endmodule